// File: doc/BRIEF.md
# Converter Host Serial Port

This block is the host side of a three-wire serial link into a dual-slope converter. A direction input picks the transfer mode, a serial clock paces the bits, and one data line runs each way. While the direction input is low the host writes an 8-bit timebase load value, most significant bit first. The port samples one bit on each rising serial-clock edge. When the direction input returns high, the port checks the received byte and commits it. A valid byte is handed to the conversion timebase together with a one-cycle start strobe.

While the direction input is high the port sends a result frame. Before the first falling clock edge the output shows the live ready level from the sequencer, so a host can poll for a finished conversion without a separate wire. Each falling edge then advances the output by one bit through a snapshot of the result: overrange, sign, and then the magnitude from its most significant bit down. The serial inputs are sampled by a system clock that runs at least four times as fast as the serial clock, through two-flop synchronizers and edge detectors.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, load_o equals the RESET_LOAD parameter (default 8'h00), sdo_oe_o and sdo_o are 0, and start_o, short_err_o and busy_err_o are 0.
- R2: With rw_i low, sdi_i is shifted in on each rising sclk_i edge, first bit into the most significant position. When rw_i then rises with exactly 8 bits received and rdy_i high, load_o takes the byte and start_o pulses for one clk cycle.
- R3: If more than 8 bits are received in one write session, the last 8 bits received are committed.
- R4: If 1 to 7 bits are received before rw_i rises, short_err_o pulses for one cycle, load_o keeps its previous value and start_o does not pulse.
- R5: If rdy_i is low when rw_i rises after a write session with at least one bit, busy_err_o pulses for one cycle, load_o is unchanged and start_o does not pulse. This check takes priority over R4. At most one of start_o, short_err_o and busy_err_o is high in any cycle.
- R6: With rw_i high, the output bit advances on each falling sclk_i edge through the frame: overrange, sign, then data_i from the most significant bit to the least. After the last data bit, sdo_o is 0.
- R7: The frame is captured from ovr_i, neg_i and data_i when the synchronized direction rises. Later changes to these inputs do not alter the frame being sent.
- R8: sdo_oe_o is high exactly while the synchronized direction is high. When sdo_oe_o is low, sdo_o is 0.
- R9: While rw_i is high and before the first falling sclk_i edge of the read, sdo_o follows rdy_i combinationally.
- R10: If rw_i goes low and returns high with no rising sclk_i edge in between, nothing is committed, no error is flagged and load_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rw_i | input | 1 | Direction: 1 = read frame, 0 = write load value |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| rdy_i | input | 1 | Sequencer ready level (auto-zero phase, result available) |
| ovr_i | input | 1 | Overrange flag of the held result |
| neg_i | input | 1 | Sign of the held result |
| data_i | input | DATA_W | Held conversion magnitude |
| load_o | output | LOAD_W | Committed timebase load value |
| start_o | output | 1 | One-cycle start-conversion strobe |
| short_err_o | output | 1 | One-cycle pulse: write session too short |
| busy_err_o | output | 1 | One-cycle pulse: write committed outside ready phase |

## Verification
The bench targets the commit decision. It sends an exact byte, an over-long write, a short write, a write while the sequencer is busy, and a direction toggle with no clock edges. A design that counted bits wrongly would commit the short write or flag the toggle. A design with the wrong precedence would report a short write instead of a busy one. On the read side the bench changes rdy_i before the first falling edge and expects the output to follow it. It also changes the result inputs in the middle of a frame. A design that loaded the frame late, or read the live inputs during the frame, would send mixed data.

// File: rtl/convsp_pkg.sv
package convsp_pkg;
  typedef enum logic [1:0] {
    CMT_NONE  = 2'd0,
    CMT_OK    = 2'd1,
    CMT_SHORT = 2'd2,
    CMT_BUSY  = 2'd3
  } commit_e;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/sp_wr_path.sv
module sp_wr_path
  import convsp_pkg::*;
#(
  parameter int              LOAD_W     = 8,
  parameter logic [LOAD_W-1:0] RESET_LOAD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rw_s,
  input  logic              rw_rise,
  input  logic              rw_fall,
  input  logic              sclk_rise,
  input  logic              sdi_s,
  input  logic              rdy_i,
  output logic [LOAD_W-1:0] load_o,
  output logic              start_o,
  output logic              short_err_o,
  output logic              busy_err_o
);
  localparam int CNT_W = $clog2(LOAD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOAD_W);

  logic [LOAD_W-1:0] sh_q, sh_n, load_q, load_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  commit_e           cmt;
  logic              bit_en;

  always_comb begin
    bit_en = !rw_s && sclk_rise;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    if (bit_en) begin
      sh_n = {sh_q[LOAD_W-2:0], sdi_s};
      if (cnt_q != CNT_FULL) cnt_n = cnt_q + 1'b1;
    end
    if (rw_rise || rw_fall) cnt_n = '0;

    cmt = CMT_NONE;
    if (rw_rise && cnt_q != '0) begin
      if (!rdy_i)                cmt = CMT_BUSY;
      else if (cnt_q < CNT_FULL) cmt = CMT_SHORT;
      else                       cmt = CMT_OK;
    end
    load_n = (cmt == CMT_OK) ? sh_q : load_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q        <= '0;
      cnt_q       <= '0;
      load_q      <= RESET_LOAD;
      start_o     <= 1'b0;
      short_err_o <= 1'b0;
      busy_err_o  <= 1'b0;
    end else begin
      sh_q        <= sh_n;
      cnt_q       <= cnt_n;
      load_q      <= load_n;
      start_o     <= (cmt == CMT_OK);
      short_err_o <= (cmt == CMT_SHORT);
      busy_err_o  <= (cmt == CMT_BUSY);
    end
  end

  assign load_o = load_q;
endmodule

// File: rtl/sp_rd_path.sv
module sp_rd_path #(
  parameter int DATA_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rw_s,
  input  logic              rw_rise,
  input  logic              sclk_fall,
  input  logic              rdy_i,
  input  logic              ovr_i,
  input  logic              neg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int FRAME_W = DATA_W + 2;

  logic [FRAME_W-1:0] frame_q, frame_n;
  logic               started_q, started_n;

  always_comb begin
    frame_n   = frame_q;
    started_n = started_q;
    if (rw_rise) begin
      frame_n   = {ovr_i, neg_i, data_i};
      started_n = 1'b0;
    end else if (rw_s && sclk_fall) begin
      if (started_q) frame_n = {frame_q[FRAME_W-2:0], 1'b0};
      started_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= '0;
      started_q <= 1'b0;
    end else begin
      frame_q   <= frame_n;
      started_q <= started_n;
    end
  end

  assign sdo_oe_o = rw_s;
  assign sdo_o    = rw_s & (started_q ? frame_q[FRAME_W-1] : rdy_i);
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
  parameter int                LOAD_W      = 8,
  parameter int                DATA_W      = 17,
  parameter int                SYNC_STAGES = 2,
  parameter logic [LOAD_W-1:0] RESET_LOAD  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rw_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              rdy_i,
  input  logic              ovr_i,
  input  logic              neg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [LOAD_W-1:0] load_o,
  output logic              start_o,
  output logic              short_err_o,
  output logic              busy_err_o
);
  logic [2:0] sync_q;
  logic       rw_s, sclk_s, sdi_s;
  logic       rw_d, sclk_d;
  logic       rw_rise, rw_fall, sclk_rise, sclk_fall;

  sp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({rw_i, sclk_i, sdi_i}), .q_o(sync_q)
  );
  assign {rw_s, sclk_s, sdi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      rw_d   <= rw_s;
      sclk_d <= sclk_s;
    end
  end

  assign rw_rise   = rw_s & ~rw_d;
  assign rw_fall   = ~rw_s & rw_d;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  sp_wr_path #(.LOAD_W(LOAD_W), .RESET_LOAD(RESET_LOAD)) u_wr (
    .clk(clk), .rst_n(rst_n), .rw_s(rw_s), .rw_rise(rw_rise), .rw_fall(rw_fall),
    .sclk_rise(sclk_rise), .sdi_s(sdi_s), .rdy_i(rdy_i), .load_o(load_o),
    .start_o(start_o), .short_err_o(short_err_o), .busy_err_o(busy_err_o)
  );

  sp_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rw_s(rw_s), .rw_rise(rw_rise), .sclk_fall(sclk_fall),
    .rdy_i(rdy_i), .ovr_i(ovr_i), .neg_i(neg_i), .data_i(data_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );
endmodule

// File: rtl/convsp_chk.sv
module convsp_chk #(
  parameter int LOAD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rw_rise,
  input logic              rdy_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic [LOAD_W-1:0] load_o,
  input logic              start_o,
  input logic              short_err_o,
  input logic              busy_err_o
);
  p_start_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(rw_rise));

  p_load_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |-> $stable(load_o));

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, short_err_o, busy_err_o}));

  p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err_o |-> $past(!rdy_i));

  p_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> !sdo_o);

  p_oe_on_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> rw_rise);
endmodule

bind conv_serial_port convsp_chk #(.LOAD_W(LOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rw_rise(rw_rise), .rdy_i(rdy_i), .sdo_o(sdo_o),
  .sdo_oe_o(sdo_oe_o), .load_o(load_o), .start_o(start_o),
  .short_err_o(short_err_o), .busy_err_o(busy_err_o)
);

// File: tb/sim_conv_serial_port.sv
module sim_conv_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int LOAD_W = 8;
  localparam int DATA_W = 17;
  localparam int FRAME_W = DATA_W + 2;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rw_i = 1'b1, sclk_i = 1'b0, sdi_i = 1'b0;
  logic rdy_i = 1'b1, ovr_i = 1'b0, neg_i = 1'b0;
  logic [DATA_W-1:0] data_i = '0;
  logic sdo_o, sdo_oe_o, start_o, short_err_o, busy_err_o;
  logic [LOAD_W-1:0] load_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // scoreboard item: {kind[1:0], load[7:0]}; kind 1 = start, 2 = short, 3 = busy
  logic [9:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .rw_i(rw_i), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .rdy_i(rdy_i), .ovr_i(ovr_i),
    .neg_i(neg_i), .data_i(data_i), .load_o(load_o), .start_o(start_o),
    .short_err_o(short_err_o), .busy_err_o(busy_err_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected commit outcomes as the design reports them
  always @(negedge clk) begin
    if (rst_n && (start_o || short_err_o || busy_err_o)) begin
      logic [1:0] kind;
      kind = start_o ? 2'd1 : (short_err_o ? 2'd2 : 2'd3);
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected outcome", kind, 0);
      end else begin
        logic [9:0] it;
        it = exp_q.pop_front();
        chk(kind == it[9:8], "R2/R4/R5 outcome kind", kind, it[9:8]);
        chk(load_o == it[7:0], "R2/R3/R4/R5 load value", load_o, it[7:0]);
      end
    end
  end

  task automatic write_bits(input int n, input logic [15:0] val);
    rw_i = 1'b0;
    repeat (8) @(posedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_i = val[i];
      repeat (3) @(posedge clk);
      sclk_i = 1'b1;
      repeat (HALF) @(posedge clk);
      sclk_i = 1'b0;
      repeat (HALF) @(posedge clk);
    end
  endtask

  task automatic commit();
    rw_i = 1'b1;
    repeat (12) @(posedge clk);
  endtask

  task automatic fall_edge();
    sclk_i = 1'b1;
    repeat (HALF) @(posedge clk);
    sclk_i = 1'b0;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [FRAME_W-1:0] fr;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(load_o == 8'h00, "R1 load_o", load_o, 0);
    chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R1 sdo idle", {sdo_oe_o, sdo_o}, 0);
    chk({start_o, short_err_o, busy_err_o} == 3'b0, "R1 strobes",
        {start_o, short_err_o, busy_err_o}, 0);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);

    // R2 exact byte
    exp_q.push_back({2'd1, 8'hA5});
    write_bits(8, 16'h00A5);
    @(negedge clk);
    chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R8 released in write", {sdo_oe_o, sdo_o}, 0);
    commit();
    chk(load_o == 8'hA5, "R2 committed", load_o, 8'hA5);

    // R3 over-long write keeps last eight
    exp_q.push_back({2'd1, 8'hC3});
    write_bits(11, 16'h05C3);
    commit();
    chk(load_o == 8'hC3, "R3 last eight", load_o, 8'hC3);

    // R4 short write
    exp_q.push_back({2'd2, 8'hC3});
    write_bits(5, 16'h001F);
    commit();
    chk(load_o == 8'hC3, "R4 unchanged", load_o, 8'hC3);

    // R5 busy (with short length too: busy wins)
    rdy_i = 1'b0;
    exp_q.push_back({2'd3, 8'hC3});
    write_bits(3, 16'h0005);
    commit();
    exp_q.push_back({2'd3, 8'hC3});
    write_bits(8, 16'h0011);
    commit();
    chk(load_o == 8'hC3, "R5 unchanged", load_o, 8'hC3);
    rdy_i = 1'b1;

    // R10 toggle with no bits
    write_bits(0, 16'h0);
    commit();
    chk(load_o == 8'hC3 && exp_q.size() == 0, "R10 no commit", load_o, 8'hC3);

    // R6 / R8 / R9 read frame
    ovr_i = 1'b1; neg_i = 1'b0; data_i = 17'h12345;
    fr = {1'b1, 1'b0, 17'h12345};
    rw_i = 1'b0;
    repeat (8) @(posedge clk);
    rw_i = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(sdo_oe_o == 1'b1, "R8 enabled in read", sdo_oe_o, 1);
    chk(sdo_o == 1'b1, "R9 poll ready high", sdo_o, 1);
    rdy_i = 1'b0;
    #1;
    chk(sdo_o == 1'b0, "R9 poll ready low", sdo_o, 0);
    rdy_i = 1'b1;
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      fall_edge();
      chk(sdo_o == fr[i], "R6 frame bit", sdo_o, fr[i]);
    end
    fall_edge();
    chk(sdo_o == 1'b0, "R6 past end", sdo_o, 0);
    rw_i = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(sdo_oe_o == 1'b0 && sdo_o == 1'b0, "R8 released after read", {sdo_oe_o, sdo_o}, 0);

    // R7 snapshot: inputs change mid-frame
    ovr_i = 1'b0; neg_i = 1'b1; data_i = 17'h0F0F1;
    fr = {1'b0, 1'b1, 17'h0F0F1};
    rw_i = 1'b1;
    repeat (8) @(posedge clk);
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      fall_edge();
      chk(sdo_o == fr[i], "R7 frame bit", sdo_o, fr[i]);
      if (i == FRAME_W - 3) begin
        ovr_i = 1'b1; neg_i = 1'b0; data_i = 17'h1AAAA;
      end
    end
    rw_i = 1'b0;
    repeat (12) @(posedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule